// File: doc/BRIEF.md
# Serial EEPROM Command Sequencer

This block runs single-word transfers to a small three-wire serial EEPROM. The host gives it a 2-bit operation, a 6-bit word address and, for writes, a 16-bit data word, then pulses `start`. The block accepts that request only while it is idle. It raises `busy` and frames the command on chip select, serial clock and serial data out. For reads it collects the returned word into `rdata`.

After a write or an erase, the block drops chip select for one serial clock period and raises it again. It then watches serial data in, which the device holds low while it is programming. When the input reads high, the block lowers `busy` by itself. If the device never reports ready, a poll limit ends the wait and sets a sticky `timeout` flag. Operation 00 carries the write-enable and write-disable commands, which differ only in the upper address bits.

Top module: `eeprom_seq`

## Requirements
- R1: After reset, `busy`, `cs`, `sk`, `sd_out` and `timeout` are 0 and `rdata` is 0.
- R2: A `start` pulse seen while idle is accepted, and `busy` is 1 from the following cycle. `busy` returns to 0 on its own at the end of the operation, with `cs` and `sk` low.
- R3: Every frame begins with chip select high and goes out MSB first: a start bit of 1, then `op[1:0]`, then `addr[5:0]`. Operation codes are 11 = erase, 10 = read, 01 = write, 00 = write enable/disable. A write (op 01) then sends `wdata[15:0]` MSB first, for 25 serial clocks.
- R4: Operation 00 sends a 9-clock frame with no ready poll. Address bits [5:4] = 11 give write enable and [5:4] = 00 give write disable; both are sent as given.
- R5: A read (op 10) keeps `sd_out` low after the address. It lasts 26 serial clocks: one dummy bit is discarded, and the next 16 bits sampled (MSB first) are loaded into `rdata` when `busy` falls. Other operations leave `rdata` unchanged.
- R6: Each serial clock half period lasts CLK_DIV system clocks. `sk` is high only while `cs` is high. `sd_out` changes only while `sk` is low, and `sd_in` is sampled when `sk` rises.
- R7: After a write or an erase frame, `cs` stays low for exactly 2*CLK_DIV cycles and then rises. `sd_in` is then sampled once every CLK_DIV cycles, and the first high sample ends the operation.
- R8: A `start` seen while `busy` is 1 is ignored. It does not change the frame being sent or the length of the operation.
- R9: If POLL_LIMIT successive poll samples are low, the operation ends and `timeout` becomes 1. `timeout` stays 1 until reset. A ready seen on the last allowed sample ends the operation without a timeout.
- R10: With N frame clocks, `busy` lasts 2*N*CLK_DIV cycles for reads and op 00. For writes and erases it lasts (2*N+2+k)*CLK_DIV cycles, where k is the number of poll samples taken.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request a transfer (taken only when idle) |
| op | input | 2 | Operation code |
| addr | input | 6 | EEPROM word address / enable-disable selector |
| wdata | input | 16 | Word to write |
| busy | output | 1 | Transfer in progress |
| rdata | output | 16 | Word returned by the last read |
| timeout | output | 1 | Sticky ready-poll timeout flag |
| cs | output | 1 | EEPROM chip select |
| sk | output | 1 | EEPROM serial clock |
| sd_out | output | 1 | Serial data to the EEPROM |
| sd_in | input | 1 | Serial data / ready from the EEPROM |

## Verification
Assertions check the signal discipline on every cycle:
- the serial clock never runs without chip select;
- data out never moves while the clock is high;
- a start arriving mid-transfer leaves the latched request untouched;
- `rdata` changes only as `busy` falls;
- `timeout` never falls once set.

Only the bench scenarios can show that the frames carry the right bits in the right order and that the read word is assembled correctly. They also show that the programming gap and the poll count have the right lengths, and how `busy` behaves on the boundary where ready arrives on the final allowed poll.

// File: rtl/eeprom_seq.sv
module eeprom_seq #(
  parameter int CLK_DIV    = 4,
  parameter int POLL_LIMIT = 1024
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [1:0]  op,
  input  logic [5:0]  addr,
  input  logic [15:0] wdata,
  output logic        busy,
  output logic [15:0] rdata,
  output logic        timeout,
  output logic        cs,
  output logic        sk,
  output logic        sd_out,
  input  logic        sd_in
);

  localparam int DIVW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam int PW   = $clog2(POLL_LIMIT + 1);

  typedef enum logic [1:0] {S_IDLE, S_SHIFT, S_GAP, S_POLL} st_t;

  st_t             st;
  logic [DIVW-1:0] div;
  logic            ph;
  logic [24:0]     sh;
  logic [4:0]      bitn, last;
  logic            pgm, rd;
  logic [15:0]     din;
  logic [PW-1:0]   pcnt;

  wire tick = (st != S_IDLE) && (div == DIVW'(CLK_DIV - 1));

  assign busy   = (st != S_IDLE);
  assign cs     = (st == S_SHIFT) || (st == S_POLL);
  assign sk     = (st == S_SHIFT) && ph;
  assign sd_out = (st == S_SHIFT) && sh[24];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      div     <= '0;
      ph      <= 1'b0;
      sh      <= '0;
      bitn    <= '0;
      last    <= '0;
      pgm     <= 1'b0;
      rd      <= 1'b0;
      din     <= '0;
      pcnt    <= '0;
      rdata   <= '0;
      timeout <= 1'b0;
    end else begin
      if (st == S_IDLE || tick) div <= '0;
      else                      div <= div + 1'b1;
      case (st)
        S_IDLE: if (start) begin
          st   <= S_SHIFT;
          ph   <= 1'b0;
          bitn <= '0;
          sh   <= {1'b1, op, addr, (op == 2'b01) ? wdata : 16'h0};
          last <= (op == 2'b01) ? 5'd24 : (op == 2'b10) ? 5'd25 : 5'd8;
          pgm  <= op[0];
          rd   <= (op == 2'b10);
          pcnt <= '0;
        end
        S_SHIFT: if (tick) begin
          if (!ph) begin
            ph  <= 1'b1;
            din <= {din[14:0], sd_in};
          end else begin
            ph <= 1'b0;
            if (bitn == last) begin
              st <= pgm ? S_GAP : S_IDLE;
              if (rd) rdata <= din;
            end else begin
              bitn <= bitn + 1'b1;
              sh   <= {sh[23:0], 1'b0};
            end
          end
        end
        S_GAP: if (tick) begin
          ph <= ~ph;
          if (ph) st <= S_POLL;
        end
        S_POLL: if (tick) begin
          if (sd_in) st <= S_IDLE;
          else if (pcnt == PW'(POLL_LIMIT - 1)) begin
            st      <= S_IDLE;
            timeout <= 1'b1;
          end else pcnt <= pcnt + 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r6_sk_needs_cs: assert property (@(posedge clk) disable iff (!rst_n)
    sk |-> cs);
  a_r6_dout_sk_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sd_out) |-> !sk);
  a_r2_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (!cs && !sk));
  a_r8_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> ($stable(last) && $stable(pgm)));
  a_r5_rdata_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rdata) |-> $fell(busy));
  a_r9_timeout_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |=> timeout);
  a_r9_timeout_ends: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout) |-> !busy);

endmodule

// File: tb/eeprom_seq_test.sv
module eeprom_seq_test;
  localparam int D   = 3;
  localparam int LIM = 8;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, sd_in = 1'b0;
  logic [1:0] op = '0;
  logic [5:0] addr = '0;
  logic [15:0] wdata = '0;
  logic busy, timeout, cs, sk, sd_out;
  logic [15:0] rdata;

  int tests = 0, fails = 0;
  logic [15:0] rdata_exp = '0;
  bit tout_exp = 1'b0;

  eeprom_seq #(.CLK_DIV(D), .POLL_LIMIT(LIM)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .addr(addr),
    .wdata(wdata), .busy(busy), .rdata(rdata), .timeout(timeout),
    .cs(cs), .sk(sk), .sd_out(sd_out), .sd_in(sd_in));

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic run(input logic [1:0] o, input logic [5:0] a,
                     input logic [15:0] d, input int w, input bit poke);
    int n, k, dur, nb, gap, pc, phase, hi, busy_err, disc_err, hi_err;
    bit pg, to_now, psk, pcs, psd, rdy, rd_bit;
    logic [25:0] expv, cap;
    n  = 9 + ((o == 2'b01) ? 16 : (o == 2'b10) ? 17 : 0);
    pg = o[0];
    k  = w / D + 1;
    to_now = pg && (k > LIM);
    if (k > LIM) k = LIM;
    dur  = 2 * n * D + (pg ? (2 + k) * D : 0);
    expv = {1'b1, o, a, (o == 2'b01) ? d : 16'h0, 1'b0};
    cap = '0; nb = 0; gap = 0; pc = 0; phase = 0; hi = 0;
    busy_err = 0; disc_err = 0; hi_err = 0;
    psk = 0; pcs = 0; psd = 0; rdy = 0; rd_bit = 0;
    @(negedge clk);
    start = 1'b1; op = o; addr = a; wdata = d;
    for (int t = 1; t <= dur + 3; t++) begin
      @(negedge clk);
      if (t == 1) start = 1'b0;
      if (poke && t == 4) begin start = 1'b1; op = 2'b11; addr = 6'h00; end
      if (poke && t == 5) start = 1'b0;
      if (busy !== (t <= dur)) busy_err++;
      if (sk && !cs) disc_err++;
      if (sk && sd_out != psd && psk) disc_err++;
      if (sk) hi++;
      if (!sk && psk) begin
        if (hi != D) hi_err++;
        hi = 0;
        if (o == 2'b10 && nb >= 9) rd_bit = (nb - 9 == 0 || nb - 9 > 16) ? 1'b0 : d[16 - (nb - 9)];
      end
      if (sk && !psk) begin
        if (nb < 26) cap[25 - nb] = sd_out;
        nb++;
      end
      if (phase == 0 && pcs && !cs && nb > 0) phase = 1;
      if (phase == 1) begin
        if (!cs) gap++;
        else begin phase = 2; pc = 1; end
      end else if (phase == 2 && cs) pc++;
      rdy   = (pc > w);
      sd_in = (phase == 2) ? rdy : rd_bit;
      psk = sk; pcs = cs; psd = sd_out;
    end
    sd_in = 1'b0;
    tout_exp = tout_exp | to_now;
    if (o == 2'b10) rdata_exp = d;
    chk(busy_err == 0, "R10", "busy cycles differing from model", busy_err, 0);
    chk(nb == n, "R3", "serial clocks in frame", nb, n);
    chk((cap >> (26 - n)) == (expv >> (26 - n)), "R3", "frame bits",
        int'(cap >> (26 - n)), int'(expv >> (26 - n)));
    chk(disc_err == 0 && hi_err == 0, "R6", "clock/data discipline errors",
        disc_err + hi_err, 0);
    if (pg) chk(gap == 2 * D, "R7", "chip select low gap", gap, 2 * D);
    else    chk(phase != 2, "R4", "no ready poll", phase, 1);
    chk(rdata == rdata_exp, "R5", "rdata", rdata, rdata_exp);
    chk(timeout == tout_exp, "R9", "timeout flag", timeout, tout_exp);
    chk(!busy && !cs && !sk, "R2", "idle after operation", {busy, cs, sk}, 0);
  endtask

  initial begin
    #2000000;
    tests++; fails++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk({busy, cs, sk, sd_out, timeout} == 5'b0, "R1", "control outputs in reset",
        {busy, cs, sk, sd_out, timeout}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rdata == 16'h0 && !busy, "R1", "rdata after reset", rdata, 0);
    run(2'b00, 6'h30, 16'h0, 0, 0);      // R4 enable
    run(2'b01, 6'h15, 16'hA5C3, 10, 0);  // R3 R7 write
    run(2'b10, 6'h2A, 16'h9E71, 0, 0);   // R5 read
    run(2'b11, 6'h07, 16'h0, 0, 0);      // R7 erase, ready at first sample
    run(2'b01, 6'h01, 16'h0F0F, 22, 0);  // R9 ready on last allowed sample
    run(2'b01, 6'h02, 16'hFFFF, 1000, 0);// R9 timeout
    run(2'b10, 6'h3F, 16'h1234, 0, 1);   // R8 start ignored mid-read
    run(2'b00, 6'h0F, 16'h0, 0, 0);      // R4 disable
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule